// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block holds a bank of programmable decode windows and maps each 36-bit CPU physical address onto a device target and an attribute byte. Each window has a control word, which carries an enable, a 4-bit target, an 8-bit attribute and a size mask, and a base word. The lower-numbered windows also carry a remap pair that moves the matched region to another physical location. Software programs the windows through a plain 32-bit register port. The decoder answers each address request one clock later with a hit or decode-error flag, the winning window number, the target, the attribute and the translated address.

The register space is not uniform. The first eight windows each own a 16-byte slot that can hold a remap pair. Sixteen reserved bytes follow that area. The remaining windows each own an 8-byte slot with only control and base. A separate clear command zeroes every register of one window in a single cycle.

Top module: `addr_win_decoder`

## Requirements
- R1: After a synchronous reset, every window register reads zero and all response outputs are zero.
- R2: The control word keeps enable in bit 0, target in bits 7:4, attribute in bits 15:8 and (size − 1) bits 31:16 in bits 31:16. Bits 3:1 read back zero.
- R3: The base word keeps address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. All other bits read back zero.
- R4: Only windows below NUM_REMAP have a remap pair. Remap-low keeps bits 31:16 only, and remap-high keeps all 32 bits. Remap offsets of the other wide-slot windows read zero and ignore writes.
- R5: Window w < 8 sits at byte offset 16·w, with control at +0, base at +4, remap-low at +8 and remap-high at +12. Window w ≥ 8 sits at 0x90 + 8·(w − 8), with control at +0 and base at +4.
- R6: Offsets 0x80–0x8F, offsets past the last window, and any offset whose low two bits are nonzero read zero and ignore writes.
- R7: A window hits only when it is enabled and (address & ~(size − 1)) equals its 36-bit base. A disabled window never hits.
- R8: On a hit in a window with a remap pair, the output address is the remap value with its size-masked low bits replaced by the request's offset bits. The remap value is remap-high bits 3:0 above remap-low bits 31:16, above 16 zero bits.
- R9: On a hit in a window with no remap pair, the output address equals the request address.
- R10: When several windows hit, the lowest-numbered window supplies the response.
- R11: On a miss, the decode-error output is 1, hit is 0, target, attribute and window are zero, and the address passes through. Exactly one of hit and decode-error is 1 for every response.
- R12: A response appears in the cycle after a request, and rsp_valid is 1 exactly then. Without a request, all response outputs are zero.
- R13: A clear command for window w zeroes its control, base and remap registers on the next edge. The clear wins over a write in the same cycle.
- R14: Address bits 35:32 take part in the compare, so a window with a nonzero high base never matches an address below 4 GiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| clr_en | input | 1 | Clear one window |
| clr_win | input | 5 | Window to clear |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 36 | CPU physical address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | Some window matched |
| rsp_miss | output | 1 | Decode error, no window matched |
| rsp_win | output | 5 | Winning window number |
| rsp_target | output | 4 | Target of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_addr | output | 36 | Translated or passed-through address |

## Verification
The assertions assume that clr_win, whenever clr_en is high, names an existing window. They also assume that software writes only sizes that are powers of two of at least 64 KiB, with a base aligned to that size. The bench therefore draws each random window's size exponent from 16 to 24 and masks its random base down to that alignment. It draws clear indices only from the configured window range. The random addresses are mostly base-plus-offset values inside a programmed window, with some fully random 36-bit addresses mixed in. This mix exercises overlaps, misses and the high address nibble.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
package awd_pkg;

    localparam int ADDR_W  = 36;
    localparam int DATA_W  = 32;
    localparam int REG_AW  = 8;
    localparam int WIN_MAX = 20;
    localparam int WIDE_SLOTS = 8;
    localparam int WIN_IW  = $clog2(WIN_MAX);
    localparam int PAGE_W  = ADDR_W - 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  tgt;
        logic        en;
    } win_ctrl_t;

    typedef struct packed {
        logic              ok;
        logic [WIN_IW-1:0] win;
        reg_sel_e          sel;
    } reg_dec_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [WIN_IW-1:0] win;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    function automatic reg_dec_t decode_reg(input logic [REG_AW-1:0] a,
                                            input int nwin,
                                            input int nremap);
        reg_dec_t d;
        logic [REG_AW-1:0] rel;
        d   = '0;
        rel = a - 8'h90;
        if (a[1:0] != 2'b00) begin
            d.ok = 1'b0;
        end else if (a < 8'h80) begin
            d.win = WIN_IW'(a[6:4]);
            d.sel = reg_sel_e'(a[3:2]);
            d.ok  = (a[3] == 1'b0) || (int'(a[6:4]) < nremap);
        end else if (a >= 8'h90) begin
            d.win = WIN_IW'(32'(WIDE_SLOTS) + 32'(rel[7:3]));
            d.sel = reg_sel_e'({1'b0, a[2]});
            d.ok  = (32'(WIDE_SLOTS) + 32'(rel[7:3])) < 32'(nwin);
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input win_ctrl_t c);
        return {c.size_m1, c.attr, c.tgt, 3'b000, c.en};
    endfunction

    function automatic win_ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        win_ctrl_t c;
        c.size_m1 = w[31:16];
        c.attr    = w[15:8];
        c.tgt     = w[7:4];
        c.en      = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] page_to_base_word(input logic [PAGE_W-1:0] p);
        return {p[15:0], 12'h000, p[19:16]};
    endfunction

    function automatic logic [PAGE_W-1:0] page_mask(input win_ctrl_t c);
        return {4'h0, c.size_m1};
    endfunction

    function automatic logic [31:0] below_mask(input logic [WIN_IW-1:0] w);
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/awd_regfile.sv
`timescale 1ns/1ps
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 clr_en,
    input  logic [WIN_IW-1:0]    clr_win,
    output win_ctrl_t            ctrl_o  [NUM_WIN],
    output logic [PAGE_W-1:0]    base_o  [NUM_WIN],
    output logic [PAGE_W-1:0]    remap_o [NUM_WIN]
);

    reg_dec_t dec;
    assign dec = decode_reg(reg_addr, NUM_WIN, NUM_REMAP);

    win_ctrl_t         ctrl_q [NUM_WIN];
    logic [PAGE_W-1:0] base_q [NUM_WIN];
    logic [15:0]       rlo_q  [NUM_REMAP];
    logic [31:0]       rhi_q  [NUM_REMAP];
    logic [15:0]       rlo_view [NUM_WIN];
    logic [31:0]       rhi_view [NUM_WIN];

    // control and base storage for every window
    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WIN; w++) begin
            if (rst) begin
                ctrl_q[w] <= '0;
                base_q[w] <= '0;
            end else if (clr_en && clr_win == WIN_IW'(w)) begin
                ctrl_q[w] <= '0;
                base_q[w] <= '0;
            end else if (reg_we && dec.ok && dec.win == WIN_IW'(w)) begin
                case (dec.sel)
                    SEL_CTRL: ctrl_q[w] <= word_to_ctrl(reg_wdata);
                    SEL_BASE: base_q[w] <= {reg_wdata[3:0], reg_wdata[31:16]};
                    default:  ;
                endcase
            end
        end
    end

    // remap pair storage only for the remappable windows
    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_REMAP; w++) begin
            if (rst) begin
                rlo_q[w] <= '0;
                rhi_q[w] <= '0;
            end else if (clr_en && clr_win == WIN_IW'(w)) begin
                rlo_q[w] <= '0;
                rhi_q[w] <= '0;
            end else if (reg_we && dec.ok && dec.win == WIN_IW'(w)) begin
                case (dec.sel)
                    SEL_RLO: rlo_q[w] <= reg_wdata[31:16];
                    SEL_RHI: rhi_q[w] <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_view
        if (w < NUM_REMAP) begin : g_rm
            assign rlo_view[w] = rlo_q[w];
            assign rhi_view[w] = rhi_q[w];
        end else begin : g_norm
            assign rlo_view[w] = '0;
            assign rhi_view[w] = '0;
        end
        assign ctrl_o[w]  = ctrl_q[w];
        assign base_o[w]  = base_q[w];
        assign remap_o[w] = {rhi_view[w][3:0], rlo_view[w]};
    end

    always_comb begin
        reg_rdata = '0;
        if (dec.ok) begin
            case (dec.sel)
                SEL_CTRL: reg_rdata = ctrl_to_word(ctrl_q[dec.win]);
                SEL_BASE: reg_rdata = page_to_base_word(base_q[dec.win]);
                SEL_RLO:  reg_rdata = {rlo_view[dec.win], 16'h0000};
                SEL_RHI:  reg_rdata = rhi_view[dec.win];
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R13: a clear leaves the named window all zero
    a_r13_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (clr_en && int'(clr_win) < NUM_WIN) |=>
            (ctrl_q[$past(clr_win)] == '0 && base_q[$past(clr_win)] == '0));

    // R4: remap-low never returns its low half
    a_r4_remap_low_half: assert property (@(posedge clk) disable iff (rst)
        (dec.ok && dec.sel == SEL_RLO) |-> reg_rdata[15:0] == 16'h0000);

    // R2: reserved control bits always read zero
    a_r2_ctrl_gap_zero: assert property (@(posedge clk) disable iff (rst)
        (dec.ok && dec.sel == SEL_CTRL) |-> reg_rdata[3:1] == 3'b000);

endmodule

// File: rtl/awd_match.sv
`timescale 1ns/1ps
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_ctrl_t         ctrl_i [NUM_WIN],
    input  logic [PAGE_W-1:0] base_i [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec
);

    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1:16];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic [PAGE_W-1:0] keep;
        assign keep       = ~page_mask(ctrl_i[w]);
        assign hit_vec[w] = ctrl_i[w].en && ((page & keep) == base_i[w]);
    end

endmodule

// File: rtl/awd_select.sv
`timescale 1ns/1ps
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_WIN-1:0] hit_vec,
    input  win_ctrl_t          ctrl_i  [NUM_WIN],
    input  logic [PAGE_W-1:0]  remap_i [NUM_WIN],
    output rsp_t               rsp_o
);

    logic              found;
    logic [WIN_IW-1:0] win_sel;
    win_ctrl_t         c_sel;
    logic [PAGE_W-1:0] m_sel;
    logic [ADDR_W-1:0] xlat;
    rsp_t              rsp_d, rsp_q;

    // lowest-numbered hit wins
    always_comb begin
        found   = 1'b0;
        win_sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i] && ctrl_i[i].en) begin
                found   = 1'b1;
                win_sel = WIN_IW'(i);
            end
        end
    end

    assign c_sel = ctrl_i[win_sel];
    assign m_sel = page_mask(c_sel);

    always_comb begin
        if (int'(win_sel) < NUM_REMAP)
            xlat = {(remap_i[win_sel] & ~m_sel) | (req_addr[ADDR_W-1:16] & m_sel),
                    req_addr[15:0]};
        else
            xlat = req_addr;
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (found) begin
                rsp_d.hit  = 1'b1;
                rsp_d.win  = win_sel;
                rsp_d.tgt  = c_sel.tgt;
                rsp_d.attr = c_sel.attr;
                rsp_d.addr = xlat;
            end else begin
                rsp_d.miss = 1'b1;
                rsp_d.addr = req_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_o = rsp_q;

    // R10: no lower-numbered window hit when a window was reported
    a_r10_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        rsp_q.hit |-> ((32'($past(hit_vec)) & below_mask(rsp_q.win)) == 32'd0));

    // R11: a decode error carries zero target and attribute
    a_r11_miss_fields_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_q.miss |-> (rsp_q.tgt == 4'h0 && rsp_q.attr == 8'h00 && rsp_q.win == '0));

    // R9: the offset inside a 64 KiB page is never altered
    a_r9_low_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_q.valid |-> rsp_q.addr[15:0] == $past(req_addr[15:0]));

endmodule

// File: rtl/addr_win_decoder.sv
`timescale 1ns/1ps
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        clr_en,
    input  logic [4:0]  clr_win,
    input  logic        req_valid,
    input  logic [35:0] req_addr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic [4:0]  rsp_win,
    output logic [3:0]  rsp_target,
    output logic [7:0]  rsp_attr,
    output logic [35:0] rsp_addr
);

    win_ctrl_t          ctrl  [NUM_WIN];
    logic [PAGE_W-1:0]  base  [NUM_WIN];
    logic [PAGE_W-1:0]  remap [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] en_vec;
    rsp_t               rsp;

    awd_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clr_en    (clr_en),
        .clr_win   (clr_win),
        .ctrl_o    (ctrl),
        .base_o    (base),
        .remap_o   (remap)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr    (req_addr),
        .ctrl_i  (ctrl),
        .base_i  (base),
        .hit_vec (hit_vec)
    );

    awd_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .hit_vec   (hit_vec),
        .ctrl_i    (ctrl),
        .remap_i   (remap),
        .rsp_o     (rsp)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_en
        assign en_vec[w] = ctrl[w].en;
    end

    assign rsp_valid  = rsp.valid;
    assign rsp_hit    = rsp.hit;
    assign rsp_miss   = rsp.miss;
    assign rsp_win    = rsp.win;
    assign rsp_target = rsp.tgt;
    assign rsp_attr   = rsp.attr;
    assign rsp_addr   = rsp.addr;

    // R12: response valid tracks the request one cycle later
    a_r12_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R12: idle cycles leave the response quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_addr == '0));

    // R11: hit and decode error are exclusive on every response
    a_r11_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R7: the reported window was enabled when the request was seen
    a_r7_hit_was_enabled: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> ((32'($past(en_vec)) >> rsp_win) & 32'd1) == 32'd1);

endmodule

// File: tb/addr_win_decoder_tb.sv
`timescale 1ns/1ps
module addr_win_decoder_tb;

    localparam int NW = 20;
    localparam int NR = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clr_en = 1'b0;
    logic [4:0]  clr_win = '0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [4:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [35:0] rsp_addr;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    logic [31:0] mreg [NW*4];
    logic [35:0] rb_base [NW];
    logic [35:0] rb_mask [NW];

    always #2.5 clk = ~clk;

    addr_win_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_en(clr_en),
        .clr_win(clr_win), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
        .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    // register map per R5/R6: slot index w*4+sel or -1
    function automatic int map_slot(input int a);
        int w, s;
        if ((a & 3) != 0) return -1;
        if (a < 'h80) begin
            w = a >> 4; s = (a >> 2) & 3;
            if (s >= 2 && w >= NR) return -1;
            return w * 4 + s;
        end
        if (a < 'h90) return -1;
        w = 8 + ((a - 'h90) >> 3); s = (a >> 2) & 1;
        if (w >= NW) return -1;
        return w * 4 + s;
    endfunction

    function automatic int off_of(input int w, input int s);
        return (w < 8) ? (w * 16 + s * 4) : ('h90 + (w - 8) * 8 + s * 4);
    endfunction

    function automatic logic [31:0] keep_mask(input int s);
        case (s)
            0: return 32'hFFFF_FFF1;
            1: return 32'hFFFF_000F;
            2: return 32'hFFFF_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] model_rd(input int a);
        int sl = map_slot(a);
        return (sl < 0) ? 32'h0 : mreg[sl];
    endfunction

    task automatic model_lookup(input logic [35:0] a, output logic h, output logic [4:0] ew,
                                output logic [3:0] et, output logic [7:0] ea,
                                output logic [35:0] eo);
        h = 0; ew = 0; et = 0; ea = 0; eo = a;
        for (int w = NW - 1; w >= 0; w--) begin
            logic [31:0] c, b;
            logic [19:0] m, bp, rp;
            c = mreg[w*4]; b = mreg[w*4+1];
            m = {4'h0, c[31:16]};
            bp = {b[3:0], b[31:16]};
            if (c[0] && ((a[35:16] & ~m) == bp)) begin
                h = 1; ew = 5'(w); et = c[7:4]; ea = c[15:8];
                if (w < NR) begin
                    rp = {mreg[w*4+3][3:0], mreg[w*4+2][31:16]};
                    eo = {(rp & ~m) | (a[35:16] & m), a[15:0]};
                end else begin
                    eo = a;
                end
            end
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        int sl = map_slot(a);
        @(negedge clk);
        reg_we = 1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (sl >= 0) mreg[sl] = d & keep_mask(sl % 4);
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = 8'(a);
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic clear_win(input int w);
        @(negedge clk);
        clr_en = 1; clr_win = 5'(w);
        @(negedge clk);
        clr_en = 0;
        for (int s = 0; s < 4; s++) mreg[w*4+s] = 0;
    endtask

    task automatic prog(input int w, input bit en, input logic [3:0] t, input logic [7:0] at,
                        input int szlog, input logic [35:0] b, input logic [35:0] r);
        logic [35:0] m = (36'h1 << szlog) - 36'h1;
        logic [15:0] sm = m[31:16];
        wr(off_of(w, 0), {sm, at, t, 3'b000, en});
        wr(off_of(w, 1), {b[31:16], 12'h000, b[35:32]});
        if (w < 8) begin
            wr(off_of(w, 2), {r[31:16], 16'h0});
            wr(off_of(w, 3), {28'h0, r[35:32]});
        end
        rb_base[w] = b; rb_mask[w] = m;
    endtask

    task automatic lookup(input logic [35:0] a, input string tag);
        logic h; logic [4:0] ew; logic [3:0] et; logic [7:0] ea; logic [35:0] eo;
        model_lookup(a, h, ew, et, ea, eo);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        chk({tag, " valid"}, 64'(rsp_valid), 64'(1));
        chk({tag, " hit"}, 64'(rsp_hit), 64'(h));
        chk({tag, " miss R11"}, 64'(rsp_miss), 64'(!h));
        chk({tag, " win"}, 64'(rsp_win), 64'(ew));
        chk({tag, " target"}, 64'(rsp_target), 64'(et));
        chk({tag, " attr"}, 64'(rsp_attr), 64'(ea));
        chk({tag, " addr"}, 64'(rsp_addr), 64'(eo));
        req_valid = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW * 4; i++) mreg[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        @(negedge clk);
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        chk("R1 rsp_addr", 64'(rsp_addr), 0);
        rd_chk('h00, 0, "R1 ctrl0");
        rd_chk('h94, 0, "R1 base8");
        rd_chk('h0C, 0, "R1 rhi0");

        // R2 control layout
        wr('h30, 32'hFFFF_FFFF);
        rd_chk('h30, 32'hFFFF_FFF1, "R2 ctrl readback");
        // R3 base layout
        wr('h9C, 32'hFFFF_FFFF);
        rd_chk('h9C, 32'hFFFF_000F, "R3 base readback");
        // R4 remap pair
        wr('h28, 32'h1234_5678);
        rd_chk('h28, 32'h1234_0000, "R4 remap low");
        wr('h2C, 32'hDEAD_BEEF);
        rd_chk('h2C, 32'hDEAD_BEEF, "R4 remap high");
        wr('h78, 32'hFFFF_FFFF);
        rd_chk('h78, 0, "R4 no remap low on window 7");
        wr('h6C, 32'hFFFF_FFFF);
        rd_chk('h6C, 0, "R4 no remap high on window 6");
        // R5 map positions
        wr('hE8, 32'hABCD_1231);
        rd_chk('hE8, 32'hABCD_1231, "R5 window 19 ctrl");
        wr('hEC, 32'h5555_0007);
        rd_chk('hEC, 32'h5555_0007, "R5 window 19 base");
        wr('h44, 32'h0001_0002);
        rd_chk('h44, 32'h0001_0002, "R5 window 4 base");
        rd_chk('h40, 0, "R5 window 4 ctrl untouched");
        // R6 reserved and unaligned
        for (int a = 'h80; a < 'h90; a += 4) begin
            wr(a, 32'hFFFF_FFFF);
            rd_chk(a, 0, "R6 reserved gap");
        end
        wr('hF0, 32'hFFFF_FFFF);
        rd_chk('hF0, 0, "R6 past last window");
        wr('h31, 32'h0000_0000);
        rd_chk('h31, 0, "R6 unaligned read");
        rd_chk('h30, 32'hFFFF_FFF1, "R6 unaligned write ignored");

        // R13 clear everything
        for (int w = 0; w < NW; w++) clear_win(w);
        rd_chk('h30, 0, "R13 ctrl cleared");
        rd_chk('h2C, 0, "R13 remap high cleared");
        rd_chk('hEC, 0, "R13 base cleared");

        // directed decode
        prog(10, 1, 4'hA, 8'h1D, 16, 36'h0_1000_0000, 0);
        lookup(36'h0_1000_0000, "R7 base edge");
        lookup(36'h0_1000_FFFF, "R7 top edge");
        lookup(36'h0_1001_0000, "R7 above window R11");
        lookup(36'h0_0FFF_FFFF, "R7 below window R11");
        prog(11, 0, 4'h3, 8'h44, 20, 36'h0_2000_0000, 0);
        lookup(36'h0_2000_0100, "R7 disabled window");
        prog(12, 1, 4'h5, 8'h66, 24, 36'h3_4000_0000, 0);
        lookup(36'h0_4000_0010, "R14 low alias");
        lookup(36'h3_40AB_CDEF, "R14 high hit");
        prog(5, 1, 4'h2, 8'h22, 28, 36'h0_6000_0000, 36'h9_0000_0000);
        prog(2, 1, 4'h7, 8'h77, 20, 36'h0_6800_0000, 36'h1_0000_0000);
        lookup(36'h0_6800_1234, "R10 overlap lower wins R8");
        lookup(36'h0_6100_0000, "R10 outer only R8");
        prog(1, 1, 4'hC, 8'hC3, 20, 36'h2_2000_0000, 36'h5_8012_0000);
        lookup(36'h2_2003_4567, "R8 remap substitution");
        prog(7, 1, 4'h9, 8'h99, 20, 36'h0_7000_0000, 36'hF_FFFF_0000);
        lookup(36'h0_7004_4444, "R9 passthrough wide slot");
        prog(15, 1, 4'hE, 8'hE1, 16, 36'hA_BCDE_0000, 0);
        lookup(36'hA_BCDE_1357, "R9 passthrough narrow slot");
        clear_win(1);
        rd_chk(off_of(1, 0), 0, "R13 window 1 ctrl");
        rd_chk(off_of(1, 2), 0, "R13 window 1 remap low");
        lookup(36'h2_2003_4567, "R13 cleared window misses");
        // R12 idle response
        @(negedge clk);
        @(negedge clk);
        chk("R12 idle valid", 64'(rsp_valid), 0);
        chk("R12 idle hit", 64'(rsp_hit | rsp_miss), 0);
        chk("R12 idle addr", 64'(rsp_addr), 0);

        // constrained random rounds
        for (int round = 0; round < 3; round++) begin
            for (int w = 0; w < NW; w++) clear_win(w);
            for (int w = 0; w < NW; w++) begin
                int szl = 16 + int'($urandom_range(0, 8));
                logic [35:0] m = (36'h1 << szl) - 36'h1;
                logic [35:0] b = {4'($urandom), 32'($urandom)} & ~m;
                logic [35:0] r = {4'($urandom), 32'($urandom)};
                if (round == 0) b[35:32] = 4'h0;
                prog(w, ($urandom_range(0, 3) != 0), 4'($urandom), 8'($urandom), szl, b, r);
            end
            for (int k = 0; k < 250; k++) begin
                logic [35:0] a;
                if ($urandom_range(0, 3) != 0) begin
                    int w = int'($urandom_range(0, NW - 1));
                    a = rb_base[w] + ({4'($urandom), 32'($urandom)} & rb_mask[w]);
                end else begin
                    a = {4'($urandom), 32'($urandom)};
                end
                lookup(a, "R7 R8 R9 R10 random");
            end
            for (int w = 0; w < NW; w++)
                rd_chk(off_of(w, 0), model_rd(off_of(w, 0)), "R2 R5 random ctrl");
        end

        finish_run();
    end

endmodule